// File: doc/BRIEF.md
# Program-Memory CRC Integrity Checker

This block verifies the contents of a read-only program memory without the processor's help. Software selects a range of whole 16 KB blocks by the index of the first block and a block count. It also supplies the CRC that the range should produce, then pulses `start`. The block reads the range one 16-bit word per clock cycle over a synchronous read port with one cycle of latency. It folds each word into a CCITT 16-bit CRC.

When the scan ends, the block holds the computed CRC in a result register and raises `done`. It compares the CRC with the expected value. A match sets `pass`. A mismatch raises the `irq` level, which stays high until the next scan is started. The check can be started again without a reset, so it serves both the start-up test and periodic tests during operation.

Top module: `flashcrc_top`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `irq` and `mem_rd_en` are all 0.
- R2: The CRC uses generator 0x1021 (x^16 + x^12 + x^5 + 1) and is seeded with 0xFFFF. Each word is shifted in most significant bit first, and no final XOR is applied. In DONE, `result` holds this CRC over the words read.
- R3: A scan reads word addresses `first*8192` through `(first+count)*8192 - 1`, each exactly once, in ascending order. One block is 16 KB, which is 8192 words.
- R4: Reads are issued back to back, one per cycle. For a count N > 0 blocks, `busy` is high for exactly N*8192 + 2 cycles.
- R5: `busy` and `done` are never high together. `pass` is 1 in DONE exactly when `result` equals the expected CRC captured at start.
- R6: `irq` is high only in DONE after a mismatch, and it is never high together with `pass`.
- R7: A `start` pulse while `busy` is high is ignored. The running scan keeps its range and expected value.
- R8: A `start` pulse in DONE begins a new scan. It clears `done`, `pass` and `irq`.
- R9: A block count of 0 issues no reads. It reaches DONE after one busy cycle with `result` = 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a scan when the block is not busy |
| cfg_first_blk | input | 4 | Index of the first 16 KB block |
| cfg_blk_cnt | input | 5 | Number of 16 KB blocks to scan (0 to 16) |
| cfg_expected | input | 16 | Expected CRC of the range |
| mem_rd_en | output | 1 | Read strobe to the program memory |
| mem_addr | output | 17 | Word address of the read |
| mem_rdata | input | 16 | Read data, valid the cycle after the strobe |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | Scan complete; result and verdict are valid |
| pass | output | 1 | Computed CRC matched the expected value |
| irq | output | 1 | Interrupt request on CRC mismatch |
| result | output | 16 | Computed CRC |

## Verification
The bench targets the read-latency offset. A datapath that folded the word before it arrived, or that stopped as soon as the last address was issued, would drop or repeat the last word. That shows up as a wrong CRC and as a busy length other than N*8192+2.

A single corrupted word, and a wrong expected value on clean data, must both raise `irq`. Either fault would slip through if the comparison or the interrupt logic were inverted.

Other corner cases are covered as well:
- A second `start` in the middle of a scan must not move the range. A design that reloaded would read the wrong addresses and report the wrong CRC.
- A zero block count must finish with the seed value and no reads.
- The highest block index must stay inside the address space.

// File: rtl/flashcrc_pkg.sv
package flashcrc_pkg;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } scan_state_t;

    typedef struct packed {
        logic        vld;
        logic [15:0] data;
    } word_beat_t;

    // Fold one 16-bit word into the CRC, most significant bit first.
    function automatic logic [15:0] crc16_word(input logic [15:0] crc_in,
                                               input logic [15:0] word);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 15; i >= 0; i--) begin
            fb = c[15] ^ word[i];
            c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return c;
    endfunction

endpackage

// File: rtl/fcrc_addr_gen.sv
module fcrc_addr_gen #(
    parameter int ADDR_W    = 17,
    parameter int BLK_LOG2  = 13,
    parameter int BLK_IDX_W = ADDR_W - BLK_LOG2,
    parameter int CNT_W     = BLK_IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 run,
    input  logic [BLK_IDX_W-1:0] first_blk,
    input  logic [CNT_W-1:0]     blk_cnt,
    output logic                 rd_en,
    output logic [ADDR_W-1:0]    addr,
    output logic                 issue_empty
);
    localparam int WORDS_W = CNT_W + BLK_LOG2;

    logic [WORDS_W-1:0] remaining;

    assign issue_empty = (remaining == '0);
    assign rd_en       = run && !issue_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr      <= '0;
            remaining <= '0;
        end else if (load) begin
            addr      <= {first_blk, {BLK_LOG2{1'b0}}};
            remaining <= {blk_cnt, {BLK_LOG2{1'b0}}};
        end else if (rd_en) begin
            addr      <= addr + 1'b1;
            remaining <= remaining - 1'b1;
        end
    end

    // Consecutive reads walk upward by one word.
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en) && !$past(rst)) |-> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/fcrc_engine.sv
module fcrc_engine
    import flashcrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  word_beat_t  beat,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc <= CRC_SEED;
        end else if (beat.vld) begin
            crc <= crc16_word(crc, beat.data);
        end
    end

    assert_seed_after_init_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(init) && !$past(rst)) |-> (crc == CRC_SEED));

endmodule

// File: rtl/fcrc_ctrl.sv
module fcrc_ctrl
    import flashcrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] expected,
    input  logic        drained,
    input  logic [15:0] crc,
    output logic        load,
    output logic        run,
    output logic        busy,
    output logic        done,
    output logic        pass,
    output logic        irq,
    output logic [15:0] result
);
    scan_state_t state, state_nx;
    logic [15:0] exp_q;

    assign load = start && (state != ST_RUN);
    assign run  = (state == ST_RUN);
    assign busy = run;
    assign done = (state == ST_DONE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)   state_nx = ST_RUN;
            ST_RUN:  if (drained) state_nx = ST_DONE;
            ST_DONE: if (start)   state_nx = ST_RUN;
            default:              state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            exp_q  <= '0;
            pass   <= 1'b0;
            irq    <= 1'b0;
            result <= '0;
        end else begin
            state <= state_nx;
            if (load) begin
                exp_q <= expected;
                pass  <= 1'b0;
                irq   <= 1'b0;
            end else if (run && drained) begin
                result <= crc;
                pass   <= (crc == exp_q);
                irq    <= (crc != exp_q);
            end
        end
    end

    assert_irq_only_fail_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done && !pass));

    assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_cfg_held_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |-> $stable(exp_q));

endmodule

// File: rtl/flashcrc_top.sv
module flashcrc_top
    import flashcrc_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int BLK_LOG2  = 13,
    parameter int BLK_IDX_W = ADDR_W - BLK_LOG2,
    parameter int CNT_W     = BLK_IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [BLK_IDX_W-1:0] cfg_first_blk,
    input  logic [CNT_W-1:0]     cfg_blk_cnt,
    input  logic [15:0]          cfg_expected,
    output logic                 mem_rd_en,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [15:0]          mem_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 pass,
    output logic                 irq,
    output logic [15:0]          result
);
    logic        load, run, issue_empty, vld_q;
    logic [15:0] crc;
    word_beat_t  beat;

    fcrc_addr_gen #(
        .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2),
        .BLK_IDX_W(BLK_IDX_W), .CNT_W(CNT_W)
    ) u_agen (
        .clk(clk), .rst(rst), .load(load), .run(run),
        .first_blk(cfg_first_blk), .blk_cnt(cfg_blk_cnt),
        .rd_en(mem_rd_en), .addr(mem_addr), .issue_empty(issue_empty)
    );

    // Read data returns one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (rst || load) vld_q <= 1'b0;
        else             vld_q <= mem_rd_en;
    end

    assign beat.vld  = vld_q;
    assign beat.data = mem_rdata;

    fcrc_engine u_eng (
        .clk(clk), .rst(rst), .init(load), .beat(beat), .crc(crc)
    );

    fcrc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .expected(cfg_expected),
        .drained(issue_empty && !vld_q), .crc(crc),
        .load(load), .run(run), .busy(busy), .done(done),
        .pass(pass), .irq(irq), .result(result)
    );

    assert_beat_in_run_R4: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> busy);

    assert_no_read_outside_run_R9: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy);

endmodule

// File: tb/flashcrc_top_bench.sv
module flashcrc_top_bench;
    localparam int BLKW = 8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  cfg_first_blk = '0;
    logic [4:0]  cfg_blk_cnt = '0;
    logic [15:0] cfg_expected = '0;
    logic        mem_rd_en;
    logic [16:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        busy, done, pass, irq;
    logic [15:0] result;

    int tests = 0;
    int fails = 0;

    // ROM model observation
    int rd_count;
    int rd_first;
    int rd_last;
    int rd_order_err;
    int corrupt_addr = -1;

    always #10 clk = ~clk;

    flashcrc_top u_flashcrc_top (
        .clk(clk), .rst(rst), .start(start),
        .cfg_first_blk(cfg_first_blk), .cfg_blk_cnt(cfg_blk_cnt),
        .cfg_expected(cfg_expected),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pass(pass), .irq(irq), .result(result)
    );

    function automatic logic [15:0] rom_word(input int a);
        int v;
        v = (a * 40503) + (a >>> 5) + 16'h5A3C;
        if (a == corrupt_addr) v = v ^ 32'h0000_0100;
        return v[15:0];
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= rom_word(int'(mem_addr));
            if (rd_count > 0 && int'(mem_addr) != rd_last + 1) rd_order_err++;
            if (rd_count == 0) rd_first = int'(mem_addr);
            rd_last = int'(mem_addr);
            rd_count++;
        end
    end

    // Reference CRC: byte-wise, high byte then low byte, MSB first.
    function automatic logic [15:0] ref_crc(input int first, input int cnt);
        logic [15:0] c;
        logic [15:0] w;
        logic [7:0]  b;
        c = 16'hFFFF;
        for (int a = first * BLKW; a < (first + cnt) * BLKW; a++) begin
            w = rom_word(a);
            for (int k = 0; k < 2; k++) begin
                b = (k == 0) ? w[15:8] : w[7:0];
                c = c ^ {b, 8'h00};
                for (int j = 0; j < 8; j++)
                    c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
            end
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input int first, input int cnt, input logic [15:0] exp);
        @(negedge clk);
        cfg_first_blk = first[3:0];
        cfg_blk_cnt   = cnt[4:0];
        cfg_expected  = exp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic clear_obs();
        rd_count = 0; rd_first = -1; rd_last = -1; rd_order_err = 0;
    endtask

    // Waits for done; returns number of busy cycles (first counted at the pulse's negedge).
    task automatic wait_done(output int busy_cyc);
        busy_cyc = 0;
        if (busy) busy_cyc = 1;
        while (!done) begin
            @(negedge clk);
            if (busy) busy_cyc++;
        end
    endtask

    task automatic scan_and_check(input int first, input int cnt, input logic [15:0] exp,
                                  input bit want_pass, input string tag);
        int bc;
        logic [15:0] golden;
        golden = ref_crc(first, cnt);
        clear_obs();
        pulse_start(first, cnt, exp);
        wait_done(bc);
        chk(result == golden, {tag, " R2 result"}, result, golden);
        chk(rd_count == cnt * BLKW, {tag, " R3 read count"}, rd_count, cnt * BLKW);
        if (cnt > 0) begin
            chk(rd_first == first * BLKW, {tag, " R3 first addr"}, rd_first, first * BLKW);
            chk(rd_last == (first + cnt) * BLKW - 1, {tag, " R3 last addr"}, rd_last,
                (first + cnt) * BLKW - 1);
            chk(rd_order_err == 0, {tag, " R3 ascending"}, rd_order_err, 0);
            chk(bc == cnt * BLKW + 2, {tag, " R4 busy cycles"}, bc, cnt * BLKW + 2);
        end
        chk(pass == want_pass, {tag, " R5 pass"}, pass, want_pass);
        chk(irq == !want_pass, {tag, " R6 irq"}, irq, !want_pass);
        chk(!busy, {tag, " R5 busy low in done"}, busy, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !pass && !irq && !mem_rd_en, "R1 reset outputs",
            {busy, done, pass, irq, mem_rd_en}, 0);
    endtask

    task automatic t_one_block_pass();
        scan_and_check(0, 1, ref_crc(0, 1), 1'b1, "one block");
    endtask

    task automatic t_64k_pass();
        scan_and_check(3, 4, ref_crc(3, 4), 1'b1, "64KB");
    endtask

    task automatic t_top_block();
        scan_and_check(15, 1, ref_crc(15, 1), 1'b1, "top block");
    endtask

    task automatic t_wrong_expected();
        logic [15:0] g;
        g = ref_crc(2, 1);
        scan_and_check(2, 1, g ^ 16'h0001, 1'b0, "wrong expected");
    endtask

    task automatic t_corrupt_word();
        logic [15:0] clean;
        clean = ref_crc(5, 1);
        corrupt_addr = 5 * BLKW + 1234;
        scan_and_check(5, 1, clean, 1'b0, "corrupt word R6");
        corrupt_addr = -1;
    endtask

    task automatic t_start_while_busy();
        int bc;
        logic [15:0] golden;
        golden = ref_crc(1, 1);
        clear_obs();
        pulse_start(1, 1, golden);
        repeat (100) @(negedge clk);
        cfg_first_blk = 4'd9; cfg_blk_cnt = 5'd2; cfg_expected = 16'h0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(bc);
        chk(result == golden, "R7 result unchanged by second start", result, golden);
        chk(pass == 1'b1 && irq == 1'b0, "R7 expected value kept", {pass, irq}, 2'b10);
        chk(rd_count == BLKW && rd_first == BLKW, "R7 range kept", rd_count, BLKW);
    endtask

    task automatic t_restart_from_done();
        logic [15:0] g;
        // previous test left done high; fail first then rerun
        g = ref_crc(6, 1);
        scan_and_check(6, 1, ~g, 1'b0, "restart pre");
        pulse_start(6, 1, g);
        chk(busy && !done && !irq && !pass, "R8 restart clears flags",
            {busy, done, irq, pass}, 4'b1000);
        begin
            int bc;
            wait_done(bc);
        end
        chk(result == g && pass && !irq, "R8 rerun passes", result, g);
    endtask

    task automatic t_zero_count();
        int bc;
        clear_obs();
        pulse_start(4, 0, 16'hFFFF);
        wait_done(bc);
        chk(rd_count == 0, "R9 no reads", rd_count, 0);
        chk(bc == 1, "R9 one busy cycle", bc, 1);
        chk(result == 16'hFFFF && pass, "R9 seed result", result, 16'hFFFF);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_obs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_one_block_pass();
        t_64k_pass();
        t_top_block();
        t_wrong_expected();
        t_corrupt_word();
        t_start_while_busy();
        t_restart_from_done();
        t_zero_count();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule